// File: doc/BRIEF.md
# Sequence-Unlocked Watchdog Timer

This block is a watchdog timer behind a small word-wide register port. Software writes a reload value, then starts the countdown by writing an ordered two-word unlock pattern to the control register. A different two-word pattern stops the countdown and reloads the counter from the reload value. While the timer runs, the count drops by one on each reference tick. A read of the control register returns the live count.

When the count reaches zero, the block raises a reset pulse. The pulse lasts a programmable number of reference ticks. The block records the hardware cause in a sticky status register and halts until software restarts it. Software can also request a reset directly, and an external PCIe reset event is recorded as a cause.

Three state machines make up the block. The unlock detector has the states SEQ_IDLE, SEQ_ARM_START and SEQ_ARM_STOP:
- A control write of 0x0000FF00 moves SEQ_IDLE to SEQ_ARM_START.
- A control write of 0x0000EE00 moves SEQ_IDLE to SEQ_ARM_STOP.
- Any control write made in an armed state returns the detector to SEQ_IDLE. It fires the start if the state is SEQ_ARM_START and the word is 0x000000FF. It fires the stop if the state is SEQ_ARM_STOP and the word is 0x000000EE.

The counter has the states CNT_HALT and CNT_RUN:
- A start moves CNT_HALT to CNT_RUN.
- A stop or an expiry moves CNT_RUN back to CNT_HALT.

The pulse generator has the states PG_IDLE and PG_ACTIVE:
- A trigger moves PG_IDLE to PG_ACTIVE.
- The tick that ends the programmed width moves PG_ACTIVE back to PG_IDLE.

Top module: `wdt_seq_top`

## Requirements
- R1: Two control writes (address 0), first 0x0000FF00 and then 0x000000FF, start the countdown. The countdown begins at the clock edge of the second write. A start while running changes nothing.
- R2: Two control writes, first 0x0000EE00 and then 0x000000EE, stop the countdown and load the live count from the reload register (address 1).
- R3: If the second control write of a pattern is not the matching partner word, the detector returns to idle and the run state and live count do not change. A partner word with no first word before it has no effect.
- R4: A read of address 0 returns the live count. While running, the count drops by one on each clock edge with ref_tick high. While halted, it holds.
- R5: A write to the reload register while running does not change the live count. The new value takes effect at the next stop.
- R6: When a tick takes the running count to zero, wd_rst_out rises at that edge and status bit 30 is set. The counter halts, and the count then stays at 0 on later ticks.
- R7: The pulse width register (address 2) gives the pulse length N. wd_rst_out stays high until the Nth ref_tick edge after the trigger, and falls at that edge.
- R8: A programmed width of 0 gives a pulse of one tick.
- R9: Writing address 3 with bit 0 = 1 raises wd_rst_out at that edge and sets status bit 29. Writing it with bit 0 = 0 has no effect.
- R10: The status register (address 4) has four cause bits: bit 31 power-on, bit 30 watchdog expiry, bit 29 software request, bit 28 set while the pcie_rst_evt input is high. Bits 27:0 read 0, and unmapped addresses read 0.
- R11: A power-on reset (por_n low) sets status to 0x80000000, halts the timer, and sets both the reload value and the live count to INIT_COUNT. wd_rst_out is low after it. Cause bits never clear except through power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ref_tick | input | 1 | One-cycle enable per reference tick |
| pcie_rst_evt | input | 1 | PCIe reset event, recorded as a cause |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| wd_rst_out | output | 1 | Generated reset pulse |

## Verification
The assertions assume three things about the inputs:
- ref_tick is a single-cycle enable.
- Register writes and ticks are sampled at the same rising edge.
- No control write lands in the cycle being checked, so the counting checks exclude those cycles explicitly.

The bench drives every input on the falling edge. Each write and each tick lasts exactly one clock. A write and a tick never share a cycle, so each register effect and each count step can be attributed to one cause.

// File: rtl/wdt_seq_pkg.sv
package wdt_seq_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_WIDTH  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SOFT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    localparam logic [31:0] KEY_START_A = 32'h0000_FF00;
    localparam logic [31:0] KEY_START_B = 32'h0000_00FF;
    localparam logic [31:0] KEY_STOP_A  = 32'h0000_EE00;
    localparam logic [31:0] KEY_STOP_B  = 32'h0000_00EE;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARM_START, SEQ_ARM_STOP} seq_state_t;
    typedef enum logic {CNT_HALT, CNT_RUN} cnt_state_t;
    typedef enum logic {PG_IDLE, PG_ACTIVE} pg_state_t;
endpackage

// File: rtl/wdt_seq_det.sv
module wdt_seq_det
    import wdt_seq_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        wr_ctrl,
    input  logic [31:0] wdata,
    output logic        start_go,
    output logic        stop_go
);
    seq_state_t st_q, st_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        start_go = 1'b0;
        stop_go  = 1'b0;
        if (wr_ctrl) begin
            unique case (st_q)
                SEQ_IDLE: begin
                    if (wdata == KEY_START_A)     st_d = SEQ_ARM_START;
                    else if (wdata == KEY_STOP_A) st_d = SEQ_ARM_STOP;
                end
                SEQ_ARM_START: begin
                    st_d     = SEQ_IDLE;
                    start_go = (wdata == KEY_START_B);
                end
                SEQ_ARM_STOP: begin
                    st_d    = SEQ_IDLE;
                    stop_go = (wdata == KEY_STOP_B);
                end
                default: st_d = SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdt_seq_counter.sv
module wdt_seq_counter
    import wdt_seq_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter logic [31:0] INIT_COUNT = 32'd100
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             start_go,
    input  logic             stop_go,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    cnt_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        unique case (st_q)
            CNT_HALT: if (start_go) st_d = CNT_RUN;
            CNT_RUN: begin
                if (stop_go) st_d = CNT_HALT;
                else if (tick && cnt <= ONE) begin
                    expire = 1'b1;
                    st_d   = CNT_HALT;
                end
            end
            default: st_d = CNT_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= CNT_HALT;
            cnt  <= INIT_COUNT[CNT_W-1:0];
        end else begin
            st_q <= st_d;
            if (stop_go)
                cnt <= reload;
            else if (st_q == CNT_RUN && tick && cnt != '0)
                cnt <= cnt - ONE;
        end
    end

    assign running = (st_q == CNT_RUN);
endmodule

// File: rtl/wdt_seq_pulse.sv
module wdt_seq_pulse
    import wdt_seq_pkg::*;
#(
    parameter int PW_W = 16
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            tick,
    input  logic            trig,
    input  logic [PW_W-1:0] width,
    output logic            rst_out
);
    localparam logic [PW_W-1:0] ONE = PW_W'(1);
    pg_state_t       st_q, st_d;
    logic [PW_W-1:0] left_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PG_IDLE:   if (trig) st_d = PG_ACTIVE;
            PG_ACTIVE: if (tick && left_q <= ONE) st_d = PG_IDLE;
            default:   st_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q   <= PG_IDLE;
            left_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == PG_IDLE && trig)
                left_q <= (width == '0) ? ONE : width;
            else if (st_q == PG_ACTIVE && tick)
                left_q <= left_q - ONE;
        end
    end

    always_comb rst_out = (st_q == PG_ACTIVE);
endmodule

// File: rtl/wdt_seq_top.sv
module wdt_seq_top
    import wdt_seq_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int          PW_W       = 16,
    parameter logic [31:0] INIT_COUNT = 32'd100
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        ref_tick,
    input  logic        pcie_rst_evt,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        wd_rst_out
);
    logic [CNT_W-1:0] reload_q, live_cnt;
    logic [PW_W-1:0]  width_q;
    logic [3:0]       cause_q;
    logic             start_go, stop_go, running, expire, soft_go;

    wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign soft_go = reg_wr && (reg_addr == A_SOFT) && reg_wdata[0];

    wdt_seq_det u_det (
        .clk(clk), .por_n(por_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
        .start_go(start_go), .stop_go(stop_go)
    );

    wdt_seq_counter #(.CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) u_cnt (
        .clk(clk), .por_n(por_n), .tick(ref_tick), .start_go(start_go),
        .stop_go(stop_go), .reload(reload_q), .cnt(live_cnt),
        .running(running), .expire(expire)
    );

    wdt_seq_pulse #(.PW_W(PW_W)) u_pg (
        .clk(clk), .por_n(por_n), .tick(ref_tick), .trig(expire || soft_go),
        .width(width_q), .rst_out(wd_rst_out)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            reload_q <= INIT_COUNT[CNT_W-1:0];
            width_q  <= ONE_W;
            cause_q  <= 4'b1000;
        end else begin
            if (reg_wr && reg_addr == A_RELOAD) reload_q <= reg_wdata[CNT_W-1:0];
            if (reg_wr && reg_addr == A_WIDTH)  width_q  <= reg_wdata[PW_W-1:0];
            cause_q <= cause_q | {1'b0, expire, soft_go, pcie_rst_evt};
        end
    end

    localparam logic [PW_W-1:0] ONE_W = PW_W'(1);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata = 32'(live_cnt);
            A_RELOAD: reg_rdata = 32'(reload_q);
            A_WIDTH:  reg_rdata = 32'(width_q);
            A_STATUS: reg_rdata = {cause_q, 28'd0};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

module wdt_seq_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             por_n,
    input logic             ref_tick,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             wd_rst_out,
    input logic [CNT_W-1:0] live_cnt,
    input logic             running,
    input logic [3:0]       cause_q
);
    wire ctrl_wr = reg_wr && (reg_addr == 3'd0);

    // R4
    run_dec_chk: assert property (@(posedge clk) disable iff (!por_n)
        (running && ref_tick && !ctrl_wr && live_cnt > CNT_W'(1))
        |=> live_cnt == $past(live_cnt) - CNT_W'(1));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!running && !ctrl_wr) |=> $stable(live_cnt));

    // R6
    expire_chk: assert property (@(posedge clk) disable iff (!por_n)
        (running && ref_tick && !ctrl_wr && live_cnt == CNT_W'(1))
        |=> (wd_rst_out && !running && live_cnt == '0 && cause_q[2]));

    // R11
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R11
    por_bit_chk: assert property (@(posedge clk) disable iff (!por_n)
        cause_q[3]);

    // R10
    status_low_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (reg_addr == 3'd4) |-> (reg_rdata[27:0] == 28'd0));
endmodule

bind wdt_seq_top wdt_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .por_n(por_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .wd_rst_out(wd_rst_out),
    .live_cnt(live_cnt), .running(running), .cause_q(cause_q)
);

// File: tb/wdt_seq_top_test.sv
module wdt_seq_top_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        pcie_rst_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wd_rst_out;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wdt_seq_top uut (
        .clk(clk), .por_n(por_n), .ref_tick(ref_tick), .pcie_rst_evt(pcie_rst_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wd_rst_out(wd_rst_out)
    );

    localparam int NV = 11;
    localparam logic [31:0] VEC_DATA [NV] = '{
        32'h0000FF00, 32'h00001234, 32'h000000FF, 32'h0000FF00, 32'h000000FF,
        32'h0000EE00, 32'h000000FF, 32'h0000EE00, 32'h000000EE, 32'h0000EE00,
        32'h000000EE};
    localparam logic VEC_RUN [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_tmr();
        wr(3'd0, 32'h0000FF00); wr(3'd0, 32'h000000FF);
    endtask

    task automatic stop_tmr();
        wr(3'd0, 32'h0000EE00); wr(3'd0, 32'h000000EE);
    endtask

    task automatic measure(input string req, input int expn);
        int n = 0;
        while (wd_rst_out && n < 100) begin
            tick();
            n++;
        end
        chk(req, n, expn);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int exp_cnt;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        rd(3'd4, d); chk("R11 status", d, 32'h80000000);
        rd(3'd0, d); chk("R11 live count", d, 100);
        rd(3'd1, d); chk("R11 reload", d, 100);
        chk("R11 pulse low", {31'd0, wd_rst_out}, 0);

        // R1 R2 R3 R4 vector walk
        exp_cnt = 100;
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VEC_DATA[i]);
            tick();
            if (VEC_RUN[i]) exp_cnt--;
            else exp_cnt = 100;
            rd(3'd0, d);
            chk($sformatf("R1/R2/R3/R4 vec%0d", i), d, exp_cnt);
        end

        // R5 reload write while running
        start_tmr();
        repeat (3) tick();
        rd(3'd0, d); chk("R4 count after 3 ticks", d, 97);
        wr(3'd1, 32'd5);
        tick();
        rd(3'd0, d); chk("R5 live count unaffected", d, 96);
        stop_tmr();
        rd(3'd0, d); chk("R2 reload on stop", d, 5);
        tick();
        rd(3'd0, d); chk("R4 halted holds", d, 5);

        // R6 R7 expiry with width 3
        wr(3'd2, 32'd3);
        wr(3'd1, 32'd2);
        stop_tmr();
        start_tmr();
        tick();
        rd(3'd0, d); chk("R6 count 1", d, 1);
        chk("R6 no pulse yet", {31'd0, wd_rst_out}, 0);
        tick();
        chk("R6 pulse raised", {31'd0, wd_rst_out}, 1);
        rd(3'd4, d); chk("R6 status", d, 32'hC0000000);
        measure("R7 width 3", 3);
        tick(); tick();
        rd(3'd0, d); chk("R6 holds zero", d, 0);
        chk("R6 no retrigger", {31'd0, wd_rst_out}, 0);

        // R8 width zero
        wr(3'd2, 32'd0);
        stop_tmr();
        start_tmr();
        tick(); tick();
        chk("R8 pulse raised", {31'd0, wd_rst_out}, 1);
        measure("R8 width 0 is 1", 1);

        // R9 soft reset
        wr(3'd3, 32'h0000_0002);
        chk("R9 bit0 clear no pulse", {31'd0, wd_rst_out}, 0);
        rd(3'd4, d); chk("R9 bit0 clear no cause", d, 32'hC0000000);
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h1);
        chk("R9 soft pulse", {31'd0, wd_rst_out}, 1);
        rd(3'd4, d); chk("R9 status", d, 32'hE0000000);
        measure("R9 soft width 2", 2);

        // R10 pcie cause and unmapped read
        @(negedge clk); pcie_rst_evt = 1'b1;
        @(negedge clk); pcie_rst_evt = 1'b0;
        rd(3'd4, d); chk("R10 pcie cause", d, 32'hF0000000);
        rd(3'd7, d); chk("R10 unmapped", d, 0);
        repeat (5) tick();
        rd(3'd4, d); chk("R11 sticky", d, 32'hF0000000);

        // R11 power-on again
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(3'd4, d); chk("R11 status after por", d, 32'h80000000);
        rd(3'd0, d); chk("R11 count after por", d, 100);
        tick();
        rd(3'd0, d); chk("R11 halted after por", d, 100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule